// File: doc/BRIEF.md
# Multiplexed parallel memory bus sequencer

This block runs one access at a time to an external asynchronous memory or peripheral. It takes each access from an internal host port through a ready/valid handshake. The port carries the address, the write data, the direction and a chip-select index. The block drives chip select, address-valid, output-enable and write-enable strobes. It drives a full address bus and a set of shared address/data lines, given as separate out, in and output-enable vectors. It also watches an external WAIT input. Each of the four chip-select indices has its own timing record. The record gives the bus mode, a data path of 8 or 16 bits, the byte order and WAIT use. It also gives five cycle counts that place every strobe edge.

There are three bus modes. In plain mode, data alone moves on the shared lines. In multiplexed mode, the low address goes out on the shared lines while address-valid is low, and data follows on the same lines. In two-address mode, a leading phase carries the upper address bits on the shared lines, and then the multiplexed sequence follows. A read completes with a one-cycle done pulse that carries the read data. After a write, the shared lines go on driving the last value. A turnaround gap comes before any access that must drive the lines after a read.

Top module: `pbus_seq`

## Requirements
- R1: `req_ready` is high only while no access is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each access gives exactly one single-cycle `rsp_done` pulse. In that cycle, `rsp_rdata` holds the read data.
- R2: Count cycles with k = 0 as the first cycle after acceptance, and let the main-phase counter c equal k − P, where P is the number of lead cycles. In the main phase, chip select is low for t_cs ≤ c < t_end, and the strobe is low for t_strb ≤ c ≤ t_acc. `rsp_done` fires at c = t_acc. `req_ready` rises again at c = t_end + 1. Any WAIT stall adds its length to the last three.
- R3: A read asserts only `mem_oe_n` and a write only `mem_we_n`. The two are never low together, and neither is low while `mem_cs_n` is high.
- R4: `mem_addr` carries the full request address throughout the access. In plain mode (mode code 0), address-valid is low for the first t_adv main cycles. The shared lines carry only write data during a write and are released (`mem_ad_oe` = 0) during a read.
- R5: In multiplexed mode (mode code 1), the shared lines carry `addr[DW-1:0]` with `mem_ad_oe` high while address-valid is low in the first t_adv main cycles. After that they carry write data, or they are released for a read.
- R6: In two-address mode (mode code 2), a leading phase of t_adv + 1 cycles comes first. In it, the shared lines carry `addr[AW-1:DW]` zero-extended, address-valid is low for its first t_adv cycles, and chip select is low from its cycle t_cs. The R5 sequence follows, with chip select held low from its start.
- R7: With the 8-bit path, write data leaves on bits [7:0] with bits [15:8] driven to zero. Read data is the low lane of the shared lines, zero-extended.
- R8: With the 16-bit path and big-endian order, the two bytes are swapped in both directions. With little-endian order, they pass through unchanged.
- R9: WAIT (active high) passes through two flip-flops. When WAIT use is enabled and the synchronized WAIT is high at c = t_acc, the counter holds and the strobe stays low. If WAIT falls before the clock edge that ends cycle m, done comes at k = max(P + t_acc, m + 2). With WAIT use disabled, WAIT has no effect.
- R10: After a read, TA_CYC idle cycles with all strobes high and the lines released come before an access that drives the shared lines (a write in any mode, or any multiplexed access). No gap is added otherwise.
- R11: While idle, `mem_ad_o` holds the last value driven onto the shared lines. `mem_ad_oe` stays high after a write and is low after a read or after reset.
- R12: During reset, all strobes are high, `req_ready` is 1, `rsp_done` is 0, `mem_ad_oe` is 0 and `mem_ad_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_flat | input | NUM_CS*CFG_W | One packed timing record per chip-select index, index 0 in the low bits |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_cs | input | CSW | Chip-select index of the request |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | Single-cycle completion pulse |
| rsp_rdata | output | DW | Read data, valid with rsp_done |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_wait | input | 1 | External WAIT, active high, asynchronous |
| mem_addr | output | AW | Full address bus |
| mem_ad_o | output | DW | Shared address/data lines, outgoing value |
| mem_ad_oe | output | 1 | Drive enable for the shared lines |
| mem_ad_i | input | DW | Shared address/data lines, incoming value |

## Verification
The assertions check on every cycle that the read and write strobes never overlap and stay inside chip select. They also check that no read strobe coincides with driving the shared lines, that the write strobe always comes with driving, that done lasts one cycle, that the sequencer is never ready while selected, and that the idle lines stay steady. The exact cycle of each strobe edge is shown only by the bench's scenarios, which sweep every chip-select record and both directions. The same holds for the lengths of the address phases in each mode, for lane order and width, for WAIT stretching against an arithmetic prediction, and for whether a turnaround gap appears.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    parameter int CNT_W = 4;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_AD    = 2'd1,
        MODE_AAD   = 2'd2
    } bus_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_TURN,
        PH_AHI,
        PH_MAIN
    } phase_e;

    typedef struct packed {
        bus_mode_e        mode;
        logic             wide;
        logic             big_end;
        logic             wait_en;
        logic [CNT_W-1:0] t_cs;
        logic [CNT_W-1:0] t_adv;
        logic [CNT_W-1:0] t_strb;
        logic [CNT_W-1:0] t_acc;
        logic [CNT_W-1:0] t_end;
    } cs_cfg_t;

    localparam int CFG_W = $bits(cs_cfg_t);
endpackage

// File: rtl/pbus_cfg_sel.sv
module pbus_cfg_sel
    import pbus_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CSW    = 2
) (
    input  logic [NUM_CS*CFG_W-1:0] cfg_flat,
    input  logic [CSW-1:0]          sel,
    output cs_cfg_t                 cfg
);
    cs_cfg_t tbl [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
        assign tbl[g] = cs_cfg_t'(cfg_flat[g*CFG_W +: CFG_W]);
    end

    assign cfg = tbl[sel];
endmodule

// File: rtl/pbus_wait_sync.sv
module pbus_wait_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[0], async_in};
    end

    assign sync_out = sh_q[1];
endmodule

// File: rtl/pbus_lane_fmt.sv
module pbus_lane_fmt #(
    parameter int DW = 16
) (
    input  logic          wide,
    input  logic          big_end,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] host_rdata
);
    localparam int HALF = DW / 2;

    always_comb begin
        if (!wide) begin
            bus_wdata  = {{HALF{1'b0}}, host_wdata[HALF-1:0]};
            host_rdata = {{HALF{1'b0}}, bus_rdata[HALF-1:0]};
        end else if (big_end) begin
            bus_wdata  = {host_wdata[HALF-1:0], host_wdata[DW-1:HALF]};
            host_rdata = {bus_rdata[HALF-1:0], bus_rdata[DW-1:HALF]};
        end else begin
            bus_wdata  = host_wdata;
            host_rdata = bus_rdata;
        end
    end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int  NUM_CS = 4,
    parameter int  AW     = 24,
    parameter int  DW     = 16,
    parameter int  TA_CYC = 2,
    localparam int CSW    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CS*CFG_W-1:0] cfg_flat,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_we,
    input  logic [CSW-1:0]          req_cs,
    input  logic [AW-1:0]           req_addr,
    input  logic [DW-1:0]           req_wdata,
    output logic                    rsp_done,
    output logic [DW-1:0]           rsp_rdata,
    output logic                    mem_cs_n,
    output logic                    mem_adv_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    input  logic                    mem_wait,
    output logic [AW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_ad_o,
    output logic                    mem_ad_oe,
    input  logic [DW-1:0]           mem_ad_i
);
    localparam logic [CNT_W-1:0] TA_LAST = CNT_W'(TA_CYC - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CSW-1:0]   cs;
        logic             we;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic             last_rd;
        logic             last_wr;
        logic [DW-1:0]    hold;
    } seq_st_t;

    seq_st_t st_q, st_d;
    cs_cfg_t cfg;
    logic    wait_s;
    logic [DW-1:0] wr_fmt, rd_fmt;
    logic    cs_act, adv_act, win, drive, mux, stall, need_ta;
    logic [DW-1:0] drv_val;

    // one selector serves both the incoming request and the running access
    pbus_cfg_sel #(.NUM_CS(NUM_CS), .CSW(CSW)) u_cfg (
        .cfg_flat (cfg_flat),
        .sel      ((st_q.phase == PH_IDLE) ? req_cs : st_q.cs),
        .cfg      (cfg)
    );

    pbus_wait_sync u_wsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mem_wait),
        .sync_out (wait_s)
    );

    pbus_lane_fmt #(.DW(DW)) u_lane (
        .wide       (cfg.wide),
        .big_end    (cfg.big_end),
        .host_wdata (st_q.wdata),
        .bus_rdata  (mem_ad_i),
        .bus_wdata  (wr_fmt),
        .host_rdata (rd_fmt)
    );

    assign mux     = (cfg.mode != MODE_PLAIN);
    assign stall   = cfg.wait_en && wait_s;
    assign need_ta = st_q.last_rd && (req_we || mux);

    always_comb begin
        st_d     = st_q;
        cs_act   = 1'b0;
        adv_act  = 1'b0;
        win      = 1'b0;
        drive    = 1'b0;
        drv_val  = st_q.hold;
        rsp_done = 1'b0;

        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.cs    = req_cs;
                    st_d.we    = req_we;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.cnt   = '0;
                    if (need_ta)                    st_d.phase = PH_TURN;
                    else if (cfg.mode == MODE_AAD)  st_d.phase = PH_AHI;
                    else                            st_d.phase = PH_MAIN;
                end
            end
            PH_TURN: begin
                if (st_q.cnt == TA_LAST) begin
                    st_d.cnt   = '0;
                    st_d.phase = (cfg.mode == MODE_AAD) ? PH_AHI : PH_MAIN;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_AHI: begin
                cs_act  = (st_q.cnt >= cfg.t_cs);
                adv_act = (st_q.cnt < cfg.t_adv);
                drive   = 1'b1;
                drv_val = DW'(st_q.addr[AW-1:DW]);
                if (st_q.cnt >= cfg.t_adv) begin
                    st_d.cnt   = '0;
                    st_d.phase = PH_MAIN;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: begin
                cs_act  = (st_q.cnt < cfg.t_end) &&
                          ((st_q.cnt >= cfg.t_cs) || (cfg.mode == MODE_AAD));
                adv_act = (st_q.cnt < cfg.t_adv);
                win     = (st_q.cnt >= cfg.t_strb) && (st_q.cnt <= cfg.t_acc);
                if (mux && (st_q.cnt < cfg.t_adv)) begin
                    drive   = 1'b1;
                    drv_val = st_q.addr[DW-1:0];
                end else if (st_q.we) begin
                    drive   = 1'b1;
                    drv_val = wr_fmt;
                end
                if ((st_q.cnt == cfg.t_acc) && stall) begin
                    st_d.cnt = st_q.cnt;
                end else begin
                    rsp_done = (st_q.cnt == cfg.t_acc);
                    if (st_q.cnt >= cfg.t_end) begin
                        st_d.phase   = PH_IDLE;
                        st_d.cnt     = '0;
                        st_d.last_rd = !st_q.we;
                        st_d.last_wr = st_q.we;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
        endcase

        if (drive) st_d.hold = drv_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.phase == PH_IDLE);
    assign mem_cs_n  = !cs_act;
    assign mem_adv_n = !adv_act;
    assign mem_oe_n  = !(win && !st_q.we);
    assign mem_we_n  = !(win && st_q.we);
    assign mem_addr  = st_q.addr;
    assign mem_ad_o  = drive ? drv_val : st_q.hold;
    assign mem_ad_oe = drive || ((st_q.phase == PH_IDLE) && st_q.last_wr);
    assign rsp_rdata = (rsp_done && !st_q.we) ? rd_fmt : '0;
endmodule

// File: rtl/pbus_seq_chk.sv
module pbus_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_done,
    input logic          mem_cs_n,
    input logic          mem_adv_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_ad_oe,
    input logic [DW-1:0] mem_ad_o
);
    // R3: read and write strobes are exclusive
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R3: a strobe only inside chip select
    p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

    // R4: no read strobe while the shared lines are driven
    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ad_oe);

    // R5: write strobe always comes with driven lines
    p_wr_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_ad_oe);

    // R1: done lasts one cycle
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R1: never ready while selected
    p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);

    // R11: idle lines hold their value
    p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && $past(req_ready)) |-> ($stable(mem_ad_o) && $stable(mem_ad_oe)));

    // R12: an idle sequencer raises no strobe
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n && !rsp_done));
endmodule

bind pbus_seq pbus_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_cs_n  (mem_cs_n),
    .mem_adv_n (mem_adv_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_ad_oe (mem_ad_oe),
    .mem_ad_o  (mem_ad_o)
);

// File: tb/pbus_seq_tb.sv
`timescale 1ns/1ps
module pbus_seq_tb;
    import pbus_pkg::*;

    localparam int NCS = 4;
    localparam int AW  = 24;
    localparam int DW  = 16;
    localparam int TA  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCS*CFG_W-1:0] cfg_flat;
    logic              req_valid = 1'b0, req_ready, req_we = 1'b0;
    logic [1:0]        req_cs = '0;
    logic [AW-1:0]     req_addr = '0;
    logic [DW-1:0]     req_wdata = '0;
    logic              rsp_done;
    logic [DW-1:0]     rsp_rdata;
    logic              mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n;
    logic              mem_wait = 1'b0;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_ad_o, mem_ad_i;
    logic              mem_ad_oe;

    int  n_chk = 0, n_fail = 0;
    bit  finished = 0;
    bit  last_rd = 0;
    logic [DW-1:0] last_drv = '0;
    cs_cfg_t cfgs [NCS];

    always #4 clk = ~clk;

    assign mem_ad_i = mem_addr[15:0] ^ 16'h3C96;

    pbus_seq #(.NUM_CS(NCS), .AW(AW), .DW(DW), .TA_CYC(TA)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_flat(cfg_flat),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_wait(mem_wait), .mem_addr(mem_addr),
        .mem_ad_o(mem_ad_o), .mem_ad_oe(mem_ad_oe), .mem_ad_i(mem_ad_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic cs_cfg_t mk(input int mode, input bit wide, input bit big, input bit wen,
                                   input int a, input int b, input int c, input int d, input int e);
        cs_cfg_t r;
        r.mode = bus_mode_e'(mode[1:0]);
        r.wide = wide; r.big_end = big; r.wait_en = wen;
        r.t_cs = CNT_W'(a); r.t_adv = CNT_W'(b); r.t_strb = CNT_W'(c);
        r.t_acc = CNT_W'(d); r.t_end = CNT_W'(e);
        return r;
    endfunction

    task automatic access(input int cs, input bit we, input logic [AW-1:0] addr,
                          input logic [DW-1:0] wd, input int m, input bit wait_hi);
        cs_cfg_t c = cfgs[cs];
        int mode = int'(c.mode);
        bit aad = (mode == 2), mux = (mode != 0);
        int adv = int'(c.t_adv);
        int ta = (last_rd && (we || mux)) ? TA : 0;
        int pre = ta + (aad ? adv + 1 : 0);
        int e_done = pre + int'(c.t_acc);
        int stall, fcs = -1, lcs = -1, fst = -1, lst = -1, dk = -1, rk = -1;
        int nadv = 0, ndone = 0, bad_strb = 0, bad_addr = 0, bad_wd = 0;
        logic [DW-1:0] wexp, rexp, d, rd = '0, ead, up;
        logic [AW-1:0] addr_at = '0;
        bit oe_at_rk = 0;
        logic [DW-1:0] ad_at_rk = '0;
        string tag_dn;

        if (c.wait_en && wait_hi && (m + 2 > e_done)) e_done = m + 2;
        stall = e_done - (pre + int'(c.t_acc));
        d = addr[15:0] ^ 16'h3C96;
        up = DW'(addr[AW-1:DW]);
        if (!c.wide) begin wexp = {8'h00, wd[7:0]}; rexp = {8'h00, d[7:0]}; end
        else if (c.big_end) begin wexp = {wd[7:0], wd[15:8]}; rexp = {d[7:0], d[15:8]}; end
        else begin wexp = wd; rexp = d; end

        // R1: ready before issue
        check(req_ready == 1'b1, "R1 ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_we = we; req_cs = 2'(cs); req_addr = addr; req_wdata = wd;
        if (wait_hi) mem_wait = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R1 busy after accept", int'(req_ready), 0);

        for (int k = 0; k < 64; k++) begin
            if (!mem_cs_n) begin if (fcs < 0) fcs = k; lcs = k; end
            if (!mem_oe_n || !mem_we_n) begin if (fst < 0) fst = k; lst = k; end
            if ((we && !mem_oe_n) || (!we && !mem_we_n)) bad_strb++;
            if (!mem_adv_n) begin
                nadv++;
                if (aad && k < ta + adv) ead = up;
                else if (mux) ead = addr[15:0];
                else ead = wexp;
                if (mux || we) begin
                    if (!(mem_ad_oe && mem_ad_o == ead)) bad_addr++;
                end else if (mem_ad_oe) bad_addr++;
            end
            if (!mem_we_n && !(mem_ad_oe && mem_ad_o == wexp)) bad_wd++;
            if (!mem_oe_n && mem_ad_oe) bad_wd++;
            if (rsp_done) begin
                if (dk < 0) dk = k;
                ndone++; rd = rsp_rdata; addr_at = mem_addr;
            end
            if (k > 0 && req_ready) begin
                rk = k; oe_at_rk = mem_ad_oe; ad_at_rk = mem_ad_o;
                break;
            end
            if (k == m) mem_wait = 1'b0;
            @(negedge clk);
        end
        mem_wait = 1'b0;

        tag_dn = (c.wait_en && wait_hi) ? "R9 done cycle" : "R2 done cycle";
        check(fcs == ((aad ? ta : pre) + int'(c.t_cs)), (ta > 0) ? "R10 cs first low" : "R2 cs first low",
              fcs, (aad ? ta : pre) + int'(c.t_cs));
        check(lcs == pre + int'(c.t_end) - 1 + stall, "R2 cs last low", lcs, pre + int'(c.t_end) - 1 + stall);
        check(fst == pre + int'(c.t_strb), "R2 strobe first low", fst, pre + int'(c.t_strb));
        check(lst == e_done, "R9 strobe held to done", lst, e_done);
        check(dk == e_done, tag_dn, dk, e_done);
        check(ndone == 1, "R1 single done", ndone, 1);
        check(rk == pre + int'(c.t_end) + 1 + stall, "R2 ready return", rk, pre + int'(c.t_end) + 1 + stall);
        check(bad_strb == 0, "R3 strobe kind", bad_strb, 0);
        check(nadv == (aad ? 2 * adv : adv), aad ? "R6 adv cycles" : "R5 adv cycles", nadv, aad ? 2 * adv : adv);
        check(bad_addr == 0, aad ? "R6 address phases" : (mux ? "R5 address phase" : "R4 plain lines"), bad_addr, 0);
        check(addr_at == addr, "R4 address bus", int'(addr_at), int'(addr));
        if (we) check(bad_wd == 0, c.wide ? "R8 write lanes" : "R7 write lanes", bad_wd, 0);
        else begin
            check(bad_wd == 0, "R4 released on read", bad_wd, 0);
            check(rd == rexp, c.wide ? "R8 read lanes" : "R7 read lanes", int'(rd), int'(rexp));
        end

        if (mux) last_drv = addr[15:0];
        if (we) last_drv = wexp;
        last_rd = !we;
        check(oe_at_rk == we, "R11 idle drive", int'(oe_at_rk), int'(we));
        check(ad_at_rk == last_drv, "R11 idle value", int'(ad_at_rk), int'(last_drv));
    endtask

    initial begin
        cfgs[0] = mk(0, 1, 0, 0, 0, 1, 2, 4, 6);
        cfgs[1] = mk(1, 1, 1, 1, 1, 2, 3, 5, 7);
        cfgs[2] = mk(2, 0, 0, 0, 0, 2, 3, 5, 6);
        cfgs[3] = mk(1, 0, 1, 1, 0, 1, 2, 3, 5);
        cfg_flat = {cfgs[3], cfgs[2], cfgs[1], cfgs[0]};

        repeat (3) @(negedge clk);
        // R12: reset state
        check(req_ready == 1'b1, "R12 ready", int'(req_ready), 1);
        check({mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n} == 4'hF, "R12 strobes",
              int'({mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n}), 15);
        check(mem_ad_oe == 1'b0 && rsp_done == 1'b0, "R12 lines released", int'(mem_ad_oe), 0);
        check(mem_ad_o == '0, "R12 line value", int'(mem_ad_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 2; i++)
            for (int cs = 0; cs < NCS; cs++)
                for (int j = 0; j < 2; j++)
                    access(cs, (j == 0), {8'(8'h40 + cs * 16 + i), 16'(16'h1234 + cs * 16'h0101 + i * 16'h0F0F)},
                           16'(16'hC3A0 ^ (cs << 4) ^ i ^ (j << 9)), -1, 0);

        // R10: plain read after read needs no gap, then plain write after read does
        access(0, 0, 24'h12_8001, 16'h0, -1, 0);
        access(0, 0, 24'h13_7E02, 16'h0, -1, 0);
        access(0, 1, 24'h14_0203, 16'hBEEF, -1, 0);

        // R9: stretch, early release, and ignored wait
        access(1, 0, 24'h21_5A5A, 16'h0, 12, 1);
        access(1, 1, 24'h22_A5A5, 16'h7E81, 9, 1);
        access(3, 1, 24'h23_0F0F, 16'h0055, 0, 1);
        access(0, 0, 24'h24_3333, 16'h0, 15, 1);
        access(2, 0, 24'h25_4444, 16'h0, 20, 1);

        // R11: lines still held two idle cycles later
        repeat (2) @(negedge clk);
        check(mem_ad_o == last_drv && mem_ad_oe == !last_rd, "R11 long idle", int'(mem_ad_o), int'(last_drv));

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule